// File: doc/BRIEF.md
# First/Next Error Logger with Class Tag Capture

This block takes per-transaction error reports and records them in two sticky status registers: a first-error register and a next-error register. Each report carries a transaction tag and three flags: a system-bus error, a correctable (single-bit) memory error and an uncorrectable (double-bit) memory error. A fixed priority picks one of three tag-capture registers and decides which status bit is logged.

The first-error register has two bits. The correctable bit `first_cm` is set by a lone single-bit error while that register is still empty. The generic non-fatal bit `first_gnf` is set by every other error kind. The correctable bit does not lock the first-error register. A second correctable error therefore sets `first_gnf`. Once `first_gnf` is set, every later error of any kind sets `next_gnf` in the next-error register. Software clears the status bits with a write-one-to-clear strobe. The tag registers keep their value through a clear.

Reports arrive on a valid/ready port. `rpt_ready` is held high outside reset, so the block never applies back-pressure. A report counts on every clock edge where `rpt_valid` and `rpt_ready` are both high. All logging is visible one cycle after that edge.

Top module: `err_logger`

## Requirements
- R1: An accepted report with all three flags low changes no status bit and no tag register.
- R2: An accepted report with only `rpt_sbe` set writes `rpt_id` into `sbe_id_q`. If `first_cm` and `first_gnf` are both clear, it sets `first_cm`.
- R3: An accepted report with `rpt_dbe` set writes `rpt_id` into `dbe_id_q`, whatever the other flags are. It is logged as a generic non-fatal error.
- R4: An accepted report with `rpt_bus_err` set and `rpt_dbe` clear writes `rpt_id` into `bus_id_q`. It is logged as a generic non-fatal error and never sets `first_cm`, even when `rpt_sbe` is also set.
- R5: Suppose `first_gnf` is clear. Then an erroring report sets `first_gnf` if it is generic, or if it is correctable and `first_cm` is already set.
- R6: While `first_gnf` is set, every erroring report sets `next_gnf` and leaves the first-error register as it is.
- R7: Status bits are sticky. A cycle with `clr_we` high clears each bit whose `clr_bits` position is 1: bit 0 clears `first_cm`, bit 1 clears `first_gnf`, bit 2 clears `next_gnf`. A report in the same cycle is routed on the status held before the clear, and its set wins over the clear.
- R8: A tag register changes only when a report of its own class is accepted. Clears do not affect it.
- R9: All results are visible on the first clock edge after acceptance. `rpt_ready` is high whenever reset is released.
- R10: After reset, all status bits and tag registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Report valid |
| rpt_ready | output | 1 | Report ready (high outside reset) |
| rpt_bus_err | input | 1 | System-bus error flag |
| rpt_sbe | input | 1 | Single-bit memory error flag |
| rpt_dbe | input | 1 | Double-bit memory error flag |
| rpt_id | input | ID_W | Transaction tag |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | 3 | Clear mask {next_gnf, first_gnf, first_cm} |
| first_cm | output | 1 | First-error correctable bit |
| first_gnf | output | 1 | First-error generic non-fatal bit |
| next_gnf | output | 1 | Next-error generic non-fatal bit |
| bus_id_q | output | ID_W | Tag of last bus-class report |
| sbe_id_q | output | ID_W | Tag of last single-bit-class report |
| dbe_id_q | output | ID_W | Tag of last double-bit-class report |

## Verification
Every result, whether a status bit, a tag register or the effect of a clear, is due exactly one rising edge after the cycle that holds the report or clear. There is no register stage before the update. The bench drives inputs on the falling edge and updates its reference model for that cycle. It then compares all outputs at the next falling edge, half a period after the edge that produced them. Random reports and clears are mixed with directed escalation chains and same-cycle set/clear cases, and all of them use this one-cycle timing.

// File: rtl/err_logger_pkg.sv
package err_logger_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_BUS  = 2'd1,
    CLS_SBE  = 2'd2,
    CLS_DBE  = 2'd3
  } err_cls_e;

  localparam int NUM_CLS = 3;
  localparam int CLR_W   = 3;
  localparam int CLR_CM  = 0;
  localparam int CLR_GNF = 1;
  localparam int CLR_NXT = 2;
endpackage

// File: rtl/err_classify.sv
module err_classify
  import err_logger_pkg::*;
(
  input  logic     bus_err,
  input  logic     sbe,
  input  logic     dbe,
  output err_cls_e cls
);
  always_comb begin
    if (dbe)          cls = CLS_DBE;
    else if (bus_err) cls = CLS_BUS;
    else if (sbe)     cls = CLS_SBE;
    else              cls = CLS_NONE;
  end
endmodule

// File: rtl/err_tag_bank.sv
module err_tag_bank
  import err_logger_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  err_cls_e        cls,
  input  logic [ID_W-1:0] id,
  output logic [ID_W-1:0] tag_q [NUM_CLS]
);
  for (genvar k = 0; k < NUM_CLS; k++) begin : g_tag
    localparam err_cls_e MY_CLS = err_cls_e'(k + 1);
    always_ff @(posedge clk) begin
      if (!rst_n)                      tag_q[k] <= '0;
      else if (acc && cls == MY_CLS)   tag_q[k] <= id;
    end
  end
endmodule

// File: rtl/err_status.sv
module err_status
  import err_logger_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  err_cls_e         cls,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_bits,
  output logic             first_cm,
  output logic             first_gnf,
  output logic             next_gnf
);
  logic [CLR_W-1:0] clr_m;
  logic set_cm, set_gnf, set_nxt;

  assign clr_m = clr_we ? clr_bits : '0;

  always_comb begin
    set_cm  = 1'b0;
    set_gnf = 1'b0;
    set_nxt = 1'b0;
    if (acc && cls != CLS_NONE) begin
      if (first_gnf)                       set_nxt = 1'b1;
      else if (cls == CLS_SBE && !first_cm) set_cm  = 1'b1;
      else                                 set_gnf = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_cm  <= 1'b0;
      first_gnf <= 1'b0;
      next_gnf  <= 1'b0;
    end else begin
      first_cm  <= set_cm  | (first_cm  & ~clr_m[CLR_CM]);
      first_gnf <= set_gnf | (first_gnf & ~clr_m[CLR_GNF]);
      next_gnf  <= set_nxt | (next_gnf  & ~clr_m[CLR_NXT]);
    end
  end
endmodule

// File: rtl/err_logger.sv
module err_logger
  import err_logger_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rpt_valid,
  output logic            rpt_ready,
  input  logic            rpt_bus_err,
  input  logic            rpt_sbe,
  input  logic            rpt_dbe,
  input  logic [ID_W-1:0] rpt_id,
  input  logic            clr_we,
  input  logic [2:0]      clr_bits,
  output logic            first_cm,
  output logic            first_gnf,
  output logic            next_gnf,
  output logic [ID_W-1:0] bus_id_q,
  output logic [ID_W-1:0] sbe_id_q,
  output logic [ID_W-1:0] dbe_id_q
);
  err_cls_e        cls;
  logic            acc;
  logic [ID_W-1:0] tags [NUM_CLS];

  assign rpt_ready = rst_n;
  assign acc       = rpt_valid & rpt_ready;

  err_classify u_cls (
    .bus_err (rpt_bus_err),
    .sbe     (rpt_sbe),
    .dbe     (rpt_dbe),
    .cls     (cls)
  );

  err_tag_bank #(.ID_W(ID_W)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .cls   (cls),
    .id    (rpt_id),
    .tag_q (tags)
  );

  err_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .cls       (cls),
    .clr_we    (clr_we),
    .clr_bits  (clr_bits),
    .first_cm  (first_cm),
    .first_gnf (first_gnf),
    .next_gnf  (next_gnf)
  );

  assign bus_id_q = tags[int'(CLS_BUS) - 1];
  assign sbe_id_q = tags[int'(CLS_SBE) - 1];
  assign dbe_id_q = tags[int'(CLS_DBE) - 1];
endmodule

// File: rtl/err_logger_chk.sv
module err_logger_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rpt_valid,
  input logic            rpt_ready,
  input logic            rpt_bus_err,
  input logic            rpt_sbe,
  input logic            rpt_dbe,
  input logic [ID_W-1:0] rpt_id,
  input logic            clr_we,
  input logic [2:0]      clr_bits,
  input logic            first_cm,
  input logic            first_gnf,
  input logic            next_gnf,
  input logic [ID_W-1:0] bus_id_q,
  input logic [ID_W-1:0] sbe_id_q,
  input logic [ID_W-1:0] dbe_id_q
);
  logic acc, any_err;
  assign acc     = rpt_valid & rpt_ready;
  assign any_err = rpt_bus_err | rpt_sbe | rpt_dbe;

  assert_quiet_report_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !any_err && !clr_we) |=> ($stable(first_cm) && $stable(first_gnf)
      && $stable(next_gnf) && $stable(bus_id_q) && $stable(sbe_id_q) && $stable(dbe_id_q)));

  assert_sbe_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rpt_sbe && !rpt_bus_err && !rpt_dbe) |=> (sbe_id_q == $past(rpt_id)));

  assert_dbe_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rpt_dbe) |=> (dbe_id_q == $past(rpt_id) && $stable(bus_id_q) && $stable(sbe_id_q)));

  assert_bus_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rpt_bus_err && !rpt_dbe) |=> (bus_id_q == $past(rpt_id) && $stable(sbe_id_q)));

  assert_no_cm_on_generic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (rpt_bus_err || rpt_dbe) && !first_cm) |=> !first_cm);

  assert_next_needs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(next_gnf) |-> $past(first_gnf));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (!$fell(first_cm) && !$fell(first_gnf) && !$fell(next_gnf)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !acc && clr_bits == 3'b111) |=> (!first_cm && !first_gnf && !next_gnf));

  assert_tags_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(bus_id_q) && $stable(sbe_id_q) && $stable(dbe_id_q)));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n) rpt_ready);
endmodule

bind err_logger err_logger_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/test_err_logger.sv
module test_err_logger;
  localparam int ID_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rpt_valid, rpt_ready, rpt_bus_err, rpt_sbe, rpt_dbe;
  logic [ID_W-1:0] rpt_id;
  logic            clr_we;
  logic [2:0]      clr_bits;
  logic            first_cm, first_gnf, next_gnf;
  logic [ID_W-1:0] bus_id_q, sbe_id_q, dbe_id_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic            m_cm, m_gnf, m_nxt;
  logic [ID_W-1:0] m_bus, m_sbe, m_dbe;

  always #10 clk = ~clk;

  err_logger #(.ID_W(ID_W)) i_err_logger (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "first_cm", 32'(first_cm), 32'(m_cm));
    chk(req, "first_gnf", 32'(first_gnf), 32'(m_gnf));
    chk(req, "next_gnf", 32'(next_gnf), 32'(m_nxt));
    chk(req, "bus_id_q", 32'(bus_id_q), 32'(m_bus));
    chk(req, "sbe_id_q", 32'(sbe_id_q), 32'(m_sbe));
    chk(req, "dbe_id_q", 32'(dbe_id_q), 32'(m_dbe));
  endtask

  function automatic string tag_of(logic v, logic b, logic s, logic d, logic c);
    if (v && d)      return "R3";
    if (v && b)      return "R4";
    if (v && s)      return (m_cm || m_gnf) ? "R5" : "R2";
    if (c)           return "R7";
    return "R1";
  endfunction

  // drive at falling edge, update model, compare at next falling edge
  task automatic step(logic v, logic b, logic s, logic d, logic [ID_W-1:0] id,
                      logic c, logic [2:0] cb, string req);
    logic nc, ng, nn;
    logic er;
    rpt_valid = v; rpt_bus_err = b; rpt_sbe = s; rpt_dbe = d; rpt_id = id;
    clr_we = c; clr_bits = cb;
    er = v && (b || s || d);
    nc = m_cm  & ~(c & cb[0]);
    ng = m_gnf & ~(c & cb[1]);
    nn = m_nxt & ~(c & cb[2]);
    if (er) begin
      if (m_gnf)                 nn = 1'b1;
      else if (s && !b && !d && !m_cm) nc = 1'b1;
      else                       ng = 1'b1;
      if (d)      m_dbe = id;
      else if (b) m_bus = id;
      else        m_sbe = id;
    end
    m_cm = nc; m_gnf = ng; m_nxt = nn;
    @(negedge clk);
    compare(req);
    chk("R9", "rpt_ready", 32'(rpt_ready), 32'd1);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, '0, 0, '0, "R1");
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; rpt_valid = 0; rpt_bus_err = 0; rpt_sbe = 0; rpt_dbe = 0;
    rpt_id = '0; clr_we = 0; clr_bits = '0;
    m_cm = 0; m_gnf = 0; m_nxt = 0; m_bus = '0; m_sbe = '0; m_dbe = '0;
    repeat (3) @(negedge clk);
    compare("R10");
    rst_n = 1;

    // R1: quiet report
    step(1, 0, 0, 0, 8'h11, 0, '0, "R1");
    // R2, R5, R6: correctable escalation chain
    step(1, 0, 1, 0, 8'h21, 0, '0, "R2");
    step(1, 0, 1, 0, 8'h22, 0, '0, "R5");
    step(1, 0, 1, 0, 8'h23, 0, '0, "R6");
    idle();
    // R7: clear everything, R8: tags kept
    step(0, 0, 0, 0, '0, 1, 3'b111, "R8");
    // R4: bus + single-bit logs generic, no cm
    step(1, 1, 1, 0, 8'h31, 0, '0, "R4");
    step(0, 0, 0, 0, '0, 1, 3'b010, "R7");
    // R3: double-bit with everything
    step(1, 1, 1, 1, 8'h41, 0, '0, "R3");
    step(1, 0, 0, 1, 8'h42, 0, '0, "R6");
    // R7: same-cycle set beats clear
    step(1, 0, 0, 1, 8'h43, 1, 3'b100, "R7");
    // R5: cm set then generic
    step(0, 0, 0, 0, '0, 1, 3'b111, "R7");
    step(1, 0, 1, 0, 8'h51, 0, '0, "R2");
    step(1, 1, 0, 0, 8'h52, 0, '0, "R5");
    // report with valid low ignored
    step(0, 1, 1, 1, 8'h5a, 0, '0, "R1");

    for (int i = 0; i < 400; i++) begin
      logic v, b, s, d, c;
      logic [2:0] cb;
      logic [ID_W-1:0] id;
      v = ($urandom % 4) != 0;
      b = ($urandom % 4) == 0;
      s = ($urandom % 2) == 0;
      d = ($urandom % 5) == 0;
      c = ($urandom % 6) == 0;
      cb = 3'($urandom);
      id = ID_W'($urandom);
      step(v, b, s, d, id, c, cb, tag_of(v, b, s, d, c));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule